// File: doc/BRIEF.md
# Datapath Control Input Router

This block is the control front-end of an 8-bit datapath slice. Six general routing channels arrive from the fabric. Each of nine control inputs has its own 6-to-1 routing multiplexer that picks one of those channels. The nine inputs are a control-store address (one bit per input, three by default), two FIFO-write strobes, two data-register-load strobes, a shift-in bit and a carry-in bit. Because every input has a private multiplexer, any channel can drive any input, and one channel may feed several inputs at once.

The address, shift-in and carry-in paths are level-sensitive and reach the outputs through combinational logic only. The routed address reads a small control-word store (8 words of 16 bits) asynchronously, so the word for the current cycle is ready in that same cycle. The four load strobes work differently. They are sampled on the datapath clock and passed through rising-edge detectors. A 0-to-1 transition seen at one clock edge produces a load pulse one cycle wide, and that pulse is applied at the next edge. Alongside the strobes, two 8-bit FIFO write-data buses are chosen from accumulator 0, accumulator 1 or the ALU result.

The routing selects, the FIFO data-source codes and the control words are static configuration, written through a simple synchronous write port. The load pulses are fire-and-forget: no handshake exists and no back-pressure is possible. A consumer must act on a pulse during the cycle in which it is high.

Top module: `dp_input_router`

## Requirements
- R1: Out of reset, every routing select holds channel 0 and both FIFO data-source codes hold 00 (accumulator 0). All control words read as 0 and no load pulse is high.
- R2: Each of the nine inputs has its own 3-bit select. Codes 0 to 5 pick channel 0 to 5, and codes 6 and 7 drive the input to 0. Select index map: 0..2 are address bits 0..2, 3 and 4 are FIFO 0/1 write, 5 and 6 are register 0/1 load, 7 is shift-in and 8 is carry-in.
- R3: The address output, shift-in and carry-in follow the routed channels in the same cycle, without any register stage.
- R4: The control word output equals the stored word at the routed address, read combinationally. A word write becomes visible from the cycle after the write edge.
- R5: When a load strobe is sampled low at one clock edge and high at the next, its pulse is high for exactly the one cycle that follows the second edge.
- R6: A strobe held high produces only one pulse. No further pulse appears until the strobe has been sampled low again.
- R7: A strobe that is already high when reset is released produces no pulse until it has been sampled low and then high.
- R8: Select indices 9 and 10 hold the 2-bit data-source codes (the low bits of the written value) for FIFO 0 and FIFO 1. The codes are 00 accumulator 0, 01 accumulator 1, 10 ALU result and 11 zero. The FIFO data outputs follow their sources combinationally.
- R9: The four strobe detectors are independent. An edge on one routed strobe pulses only that strobe's output.
- R10: A select write is taken at the clock edge. The edge that performs the write still samples the strobes with the old routing, and the new routing applies from the next cycle. Writes to indices above 10 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| route_ch | input | 6 | Routing channels |
| cfg_sel_we | input | 1 | Select write enable |
| cfg_sel_idx | input | 4 | Select index (0..10) |
| cfg_sel_val | input | 3 | Select value |
| cfg_word_we | input | 1 | Control word write enable |
| cfg_word_addr | input | 3 | Control word write address |
| cfg_word_data | input | 16 | Control word write data |
| acc0_i | input | 8 | Accumulator 0 |
| acc1_i | input | 8 | Accumulator 1 |
| alu_i | input | 8 | ALU result |
| ctl_addr_o | output | 3 | Routed control-store address |
| ctl_word_o | output | 16 | Control word for this cycle |
| shift_in_o | output | 1 | Routed shift-in |
| carry_in_o | output | 1 | Routed carry-in |
| fifo_ld_o | output | 2 | FIFO write pulses |
| reg_ld_o | output | 2 | Data-register load pulses |
| fifo0_din_o | output | 8 | FIFO 0 write data |
| fifo1_din_o | output | 8 | FIFO 1 write data |

## Verification
The bench drives a strobe that is already high when reset is released. A detector that reset its history to 0 would fire a false load at that point. It then holds strobes high for several cycles, where a level-sensitive or free-running detector would repeat the pulse. It writes select codes 6 and 7, which a plain index into the channel vector would decode into garbage or X instead of 0. Random select rewrites fall between strobe transitions, so a design that applied a new route in the same edge that samples the strobe would show pulses one cycle early or in the wrong place.

// File: rtl/dp_route_pkg.sv
package dp_route_pkg;

  // FIFO write-data source codes
  typedef enum logic [1:0] {
    SRC_ACC0 = 2'd0,
    SRC_ACC1 = 2'd1,
    SRC_ALU  = 2'd2,
    SRC_ZERO = 2'd3
  } fifo_src_e;

  // number of strobe inputs handled by edge detectors
  localparam int unsigned N_STROBE = 4;

endpackage

// File: rtl/dp_chan_mux.sv
module dp_chan_mux #(
  parameter int unsigned N_CH  = 6,
  parameter int unsigned SEL_W = 3
) (
  input  logic [N_CH-1:0]  ch_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             y_o
);

  // codes past the last channel leave the output at 0
  always_comb begin
    y_o = 1'b0;
    for (int i = 0; i < int'(N_CH); i++) begin
      if (sel_i == SEL_W'(i)) y_o = ch_i[i];
    end
  end

endmodule

// File: rtl/dp_edge_strobe.sv
module dp_edge_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic pulse_o
);

  logic smp_q;
  logic hist_q;

  // both stages reset high: a strobe high at reset is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b1;
      hist_q <= 1'b1;
    end else begin
      smp_q  <= lvl_i;
      hist_q <= smp_q;
    end
  end

  assign pulse_o = smp_q & ~hist_q;

endmodule

// File: rtl/dp_ctl_store.sv
module dp_ctl_store #(
  parameter int unsigned AW = 3,
  parameter int unsigned W  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 mem_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))         mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/dp_route_cfg.sv
module dp_route_cfg #(
  parameter int unsigned N_SEL = 11,
  parameter int unsigned SEL_W = 3,
  parameter int unsigned IDX_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [SEL_W-1:0]            val_i,
  output logic [N_SEL-1:0][SEL_W-1:0] sel_o
);

  for (genvar g = 0; g < int'(N_SEL); g++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             sel_o[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g))    sel_o[g] <= val_i;
    end
  end

endmodule

// File: rtl/dp_input_router.sv
module dp_input_router
  import dp_route_pkg::*;
#(
  parameter int unsigned N_CH   = 6,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_CH-1:0]                 route_ch,
  input  logic                            cfg_sel_we,
  input  logic [$clog2(ADDR_W+8)-1:0]     cfg_sel_idx,
  input  logic [$clog2(N_CH)-1:0]         cfg_sel_val,
  input  logic                            cfg_word_we,
  input  logic [ADDR_W-1:0]               cfg_word_addr,
  input  logic [WORD_W-1:0]               cfg_word_data,
  input  logic [DATA_W-1:0]               acc0_i,
  input  logic [DATA_W-1:0]               acc1_i,
  input  logic [DATA_W-1:0]               alu_i,
  output logic [ADDR_W-1:0]               ctl_addr_o,
  output logic [WORD_W-1:0]               ctl_word_o,
  output logic                            shift_in_o,
  output logic                            carry_in_o,
  output logic [1:0]                      fifo_ld_o,
  output logic [1:0]                      reg_ld_o,
  output logic [DATA_W-1:0]               fifo0_din_o,
  output logic [DATA_W-1:0]               fifo1_din_o
);

  localparam int unsigned N_IN      = ADDR_W + 6;
  localparam int unsigned IDX_STB0  = ADDR_W;
  localparam int unsigned IDX_SI    = ADDR_W + 4;
  localparam int unsigned IDX_CI    = ADDR_W + 5;
  localparam int unsigned IDX_FSRC0 = N_IN;
  localparam int unsigned IDX_FSRC1 = N_IN + 1;
  localparam int unsigned N_SEL     = N_IN + 2;
  localparam int unsigned SEL_W     = $clog2(N_CH);
  localparam int unsigned IDX_W     = $clog2(ADDR_W + 8);

  logic [N_SEL-1:0][SEL_W-1:0] sel_q;
  logic [N_IN-1:0]             routed;
  logic [N_STROBE-1:0]         stb_lvl;
  logic [N_STROBE-1:0]         stb_pulse;

  dp_route_cfg #(
    .N_SEL (N_SEL),
    .SEL_W (SEL_W),
    .IDX_W (IDX_W)
  ) cfg_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (cfg_sel_we),
    .idx_i (cfg_sel_idx),
    .val_i (cfg_sel_val),
    .sel_o (sel_q)
  );

  // one private routing multiplexer per control input
  for (genvar g = 0; g < int'(N_IN); g++) begin : g_route
    dp_chan_mux #(
      .N_CH  (N_CH),
      .SEL_W (SEL_W)
    ) mux_i (
      .ch_i  (route_ch),
      .sel_i (sel_q[g]),
      .y_o   (routed[g])
    );
  end

  // level-sensitive paths
  assign ctl_addr_o = routed[ADDR_W-1:0];
  assign shift_in_o = routed[IDX_SI];
  assign carry_in_o = routed[IDX_CI];

  // edge-sensitive load strobes: fifo0, fifo1, reg0, reg1
  assign stb_lvl = routed[IDX_STB0 +: N_STROBE];

  for (genvar g = 0; g < int'(N_STROBE); g++) begin : g_edge
    dp_edge_strobe edge_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (stb_lvl[g]),
      .pulse_o (stb_pulse[g])
    );
  end

  assign fifo_ld_o = stb_pulse[1:0];
  assign reg_ld_o  = stb_pulse[3:2];

  dp_ctl_store #(
    .AW (ADDR_W),
    .W  (WORD_W)
  ) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_word_we),
    .waddr_i (cfg_word_addr),
    .wdata_i (cfg_word_data),
    .raddr_i (ctl_addr_o),
    .rdata_o (ctl_word_o)
  );

  // FIFO write-data source selection
  fifo_src_e src0, src1;
  assign src0 = fifo_src_e'(sel_q[IDX_FSRC0][1:0]);
  assign src1 = fifo_src_e'(sel_q[IDX_FSRC1][1:0]);

  always_comb begin
    unique case (src0)
      SRC_ACC0: fifo0_din_o = acc0_i;
      SRC_ACC1: fifo0_din_o = acc1_i;
      SRC_ALU:  fifo0_din_o = alu_i;
      default:  fifo0_din_o = '0;
    endcase
    unique case (src1)
      SRC_ACC0: fifo1_din_o = acc0_i;
      SRC_ACC1: fifo1_din_o = acc1_i;
      SRC_ALU:  fifo1_din_o = alu_i;
      default:  fifo1_din_o = '0;
    endcase
  end

endmodule

// File: rtl/dp_input_router_chk.sv
module dp_input_router_chk #(
  parameter int unsigned N_SEL  = 11,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_SI = 7,
  parameter int unsigned IDX_F0 = 9
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [3:0]                  ld_vec,
  input logic [3:0]                  stb_vec,
  input logic [N_SEL-1:0][SEL_W-1:0] sel_q,
  input logic                        shift_in_o,
  input logic [DATA_W-1:0]           acc1_i,
  input logic [DATA_W-1:0]           fifo0_din_o
);

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ld_vec & $past(ld_vec)) == 4'b0000));

  for (genvar k = 0; k < 4; k++) begin : g_stb
    // R5
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_vec[k] |-> $past(stb_vec[k]));
    // R6
    held_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stb_vec[k]) && $past(stb_vec[k], 2)) |-> !ld_vec[k]);
  end

  // R2
  bad_sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q[IDX_SI] > SEL_W'(5)) |-> !shift_in_o);

  // R8
  fifo_src_acc1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q[IDX_F0][1:0] == 2'd1) |-> (fifo0_din_o == acc1_i));

endmodule

bind dp_input_router dp_input_router_chk #(
  .N_SEL  (N_SEL),
  .SEL_W  (SEL_W),
  .DATA_W (DATA_W),
  .IDX_SI (IDX_SI),
  .IDX_F0 (IDX_FSRC0)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ld_vec      ({reg_ld_o, fifo_ld_o}),
  .stb_vec     (stb_lvl),
  .sel_q       (sel_q),
  .shift_in_o  (shift_in_o),
  .acc1_i      (acc1_i),
  .fifo0_din_o (fifo0_din_o)
);

// File: tb/dp_input_router_tb_top.sv
`timescale 1ns/1ps
module dp_input_router_tb_top;

  localparam int FSRC0 = 9;
  localparam int FSRC1 = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  route_ch = '0;
  logic        cfg_sel_we = 1'b0;
  logic [3:0]  cfg_sel_idx = '0;
  logic [2:0]  cfg_sel_val = '0;
  logic        cfg_word_we = 1'b0;
  logic [2:0]  cfg_word_addr = '0;
  logic [15:0] cfg_word_data = '0;
  logic [7:0]  acc0_i = '0, acc1_i = '0, alu_i = '0;
  logic [2:0]  ctl_addr_o;
  logic [15:0] ctl_word_o;
  logic        shift_in_o, carry_in_o;
  logic [1:0]  fifo_ld_o, reg_ld_o;
  logic [7:0]  fifo0_din_o, fifo1_din_o;

  int checks = 0;
  int failures = 0;

  logic [2:0]  msel [11];
  logic [15:0] mword [8];
  logic [3:0]  s1, s2;

  always #2.5 clk = ~clk;

  dp_input_router dut_i (.*);

  function automatic logic route(logic [5:0] ch, logic [2:0] s);
    return (s < 3'd6) ? ch[s] : 1'b0;
  endfunction

  function automatic logic [7:0] pick(logic [2:0] code, logic [7:0] a0, logic [7:0] a1, logic [7:0] al);
    case (code[1:0])
      2'd0: return a0;
      2'd1: return a1;
      2'd2: return al;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_addr();
    return {route(route_ch, msel[2]), route(route_ch, msel[1]), route(route_ch, msel[0])};
  endfunction

  task automatic check_all();
    logic [2:0] a;
    a = exp_addr();
    check("R3 addr", 32'(ctl_addr_o), 32'(a));
    check("R4 word", 32'(ctl_word_o), 32'(mword[a]));
    check("R3 shift_in", 32'(shift_in_o), 32'(route(route_ch, msel[7])));
    check("R3 carry_in", 32'(carry_in_o), 32'(route(route_ch, msel[8])));
    check("R5 loads", 32'({reg_ld_o, fifo_ld_o}), 32'(s1 & ~s2));
    check("R8 fifo0 data", 32'(fifo0_din_o), 32'(pick(msel[FSRC0], acc0_i, acc1_i, alu_i)));
    check("R8 fifo1 data", 32'(fifo1_din_o), 32'(pick(msel[FSRC1], acc0_i, acc1_i, alu_i)));
  endtask

  // one clock: update the model at the edge, check at the falling edge
  task automatic step();
    @(posedge clk);
    for (int k = 0; k < 4; k++) begin
      s2[k] = s1[k];
      s1[k] = route(route_ch, msel[3 + k]);
    end
    // R10: new routing applies only after the sampling edge
    if (cfg_sel_we && cfg_sel_idx < 4'd11) msel[cfg_sel_idx] = cfg_sel_val;
    if (cfg_word_we) mword[cfg_word_addr] = cfg_word_data;
    @(negedge clk);
    check_all();
  endtask

  task automatic set_sel(int idx, int val);
    cfg_sel_we = 1'b1; cfg_sel_idx = 4'(idx); cfg_sel_val = 3'(val);
    step();
    cfg_sel_we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 11; i++) msel[i] = '0;
    for (int i = 0; i < 8; i++) mword[i] = '0;
    route_ch = 6'b000001;   // all strobes high through reset
    acc0_i = 8'h11; acc1_i = 8'h22; alu_i = 8'h33;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    s1 = 4'hF; s2 = 4'hF;
    // R1 reset state
    check("R1 loads", 32'({reg_ld_o, fifo_ld_o}), 32'h0);
    check("R1 word", 32'(ctl_word_o), 32'h0);
    check("R1 fifo0 src", 32'(fifo0_din_o), 32'h11);
    check("R1 fifo1 src", 32'(fifo1_din_o), 32'h11);

    // R7: strobe high across reset release gives no pulse
    repeat (3) step();
    check("R7 no pulse", 32'({reg_ld_o, fifo_ld_o}), 32'h0);
    route_ch = 6'b000000; step();
    route_ch = 6'b000001; step();
    check("R5 pulse after rise", 32'({reg_ld_o, fifo_ld_o}), 32'hF);
    step();
    check("R6 held high", 32'({reg_ld_o, fifo_ld_o}), 32'h0);
    step();
    check("R6 still held", 32'({reg_ld_o, fifo_ld_o}), 32'h0);

    // R9: only fifo0 strobe on channel 4
    set_sel(3, 4);
    route_ch = 6'b010001; step();
    route_ch = 6'b000001; step();
    route_ch = 6'b010001; step();
    check("R9 only fifo0", 32'({reg_ld_o, fifo_ld_o}), 32'h1);

    // R4: control word write and read back at address 5
    set_sel(0, 1); set_sel(1, 2); set_sel(2, 3);
    cfg_word_we = 1'b1; cfg_word_addr = 3'd5; cfg_word_data = 16'hA5C3;
    step();
    cfg_word_we = 1'b0;
    route_ch = 6'b001011; #0.1;
    check("R4 addr 5", 32'(ctl_addr_o), 32'd5);
    check("R4 word 5", 32'(ctl_word_o), 32'hA5C3);

    // R2: invalid code 6 and 7 give 0
    route_ch = 6'b111111;
    set_sel(7, 6);
    check("R2 code6 shift_in", 32'(shift_in_o), 32'h0);
    set_sel(8, 7);
    check("R2 code7 carry_in", 32'(carry_in_o), 32'h0);
    set_sel(8, 5);
    check("R2 code5 carry_in", 32'(carry_in_o), 32'h1);

    // R8: all data-source codes
    for (int c = 0; c < 4; c++) begin
      set_sel(FSRC0, c);
      check("R8 fifo0 code", 32'(fifo0_din_o), 32'(pick(3'(c), acc0_i, acc1_i, alu_i)));
    end
    // R10: out-of-range index ignored
    set_sel(15, 5);
    check("R10 ignored idx", 32'(fifo1_din_o), 32'h11);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      route_ch = 6'($urandom);
      acc0_i = 8'($urandom); acc1_i = 8'($urandom); alu_i = 8'($urandom);
      cfg_sel_we = ($urandom_range(0, 7) == 0);
      cfg_sel_idx = 4'($urandom_range(0, 12));
      cfg_sel_val = 3'($urandom_range(0, 7));
      cfg_word_we = ($urandom_range(0, 7) == 0);
      cfg_word_addr = 3'($urandom);
      cfg_word_data = 16'($urandom);
      step();
    end
    cfg_sel_we = 1'b0; cfg_word_we = 1'b0;
    step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule